// File: doc/BRIEF.md
# Addressing-Mode Operand Fetch Unit

This block resolves a single instruction operand under one of ten addressing modes. The caller presents a mode code, a register value, a displacement, the program counter, the stack pointer, a scale select and a step select together with a one-cycle `start`. The block works out the effective address, issues one or two word reads on a simple request port, and returns the operand with a one-cycle `done`. Under the two auto-update modes it also hands back the new register value with a write strobe, so the register file outside can commit it.

All inputs are captured when `start` is accepted, so the caller may change them on the next cycle. The memory port has a fixed read latency: data for a request made in one cycle is valid during the following cycle. Decoding of instructions, the register file and the memory itself live outside the block.

Top module: `opf_unit`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `done`, `mem_req`, `reg_wr_en` and `err` are all low.
- R2: Mode code 0 (immediate) returns the displacement as the operand, makes no memory request and raises `done` in the first cycle after the cycle in which `start` was accepted.
- R3: Mode codes 1 (direct, address D), 2 (register indirect, address R), 6 (indexed, address R+D), 8 (program-counter relative, address PC+D) and 9 (stack-pointer relative, address SP+D) make exactly one read. `mem_req` is high in the first cycle after acceptance, and `done` is high in the third cycle, carrying the word read.
- R4: Mode code 3 (memory indirect) reads a pointer from address D, then reads the operand from that pointer. Exactly two requests are made, and `done` is high in the fifth cycle after acceptance.
- R5: Mode code 7 (scaled index) reads from (R shifted left by `scale_sel`) + D, so `scale_sel` values 0, 1, 2 and 3 scale R by 1, 2, 4 and 8.
- R6: Mode code 4 (post-increment) reads from the old R, and at `done` it presents R+n on `reg_wr_data`.
- R7: Mode code 5 (pre-decrement) reads from R−n and presents R−n on `reg_wr_data` at `done`.
- R8: The step n is 1, 2, 4 or 8 for `step_sel` values 0, 1, 2 and 3.
- R9: Mode codes 10 to 15 make no memory request. They raise `err` together with `done` in the first cycle after acceptance and return an operand of zero.
- R10: `reg_wr_en` is high only in the `done` cycle of modes 4 and 5, and it is low for every other mode.
- R11: All address and register arithmetic wraps modulo 2^AW.
- R12: A `start` that arrives while an operation is in progress, or in its `done` cycle, is ignored. The running operation completes with its own captured inputs, and no extra `done` follows.
- R13: `done` is high for exactly one cycle per accepted operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| mode | input | 4 | Addressing mode code |
| reg_val | input | AW | Register operand R |
| disp | input | AW | Displacement D |
| pc | input | AW | Program counter |
| sp | input | AW | Stack pointer |
| scale_sel | input | 2 | Scale select, shift of R by 0 to 3 |
| step_sel | input | 2 | Auto-update step select, n = 1 << step_sel |
| mem_req | output | 1 | Word read request |
| mem_addr | output | AW | Read address |
| mem_rdata | input | AW | Read data, valid the cycle after the request |
| done | output | 1 | Operation complete, one cycle |
| operand | output | AW | Resolved operand, valid with done |
| err | output | 1 | Illegal mode code, valid with done |
| reg_wr_en | output | 1 | Register update strobe |
| reg_wr_data | output | AW | Updated register value |

## Verification
The bench targets the ordering difference between the two auto modes. A design that updated R on the wrong side of the access would read the neighbouring word, and the scoreboard sees that as a wrong operand. It runs every step and scale select, because a one-off error in those decoders shows up as an operand read from a misaligned address. It also drives sums that cross 2^32, where an address computed at the wrong width would land elsewhere. A `start` pulse is injected mid-operation, where a design that re-accepts would produce a second `done` that has no scoreboard entry. Illegal codes are checked to confirm they raise `err` with no request, where a design that fell through to a read would show a nonzero request count.

// File: rtl/opf_pkg.sv
package opf_pkg;

   typedef enum logic [3:0] {
      AM_IMM  = 4'd0,
      AM_DIR  = 4'd1,
      AM_RIND = 4'd2,
      AM_MIND = 4'd3,
      AM_PINC = 4'd4,
      AM_PDEC = 4'd5,
      AM_IDX  = 4'd6,
      AM_SIB  = 4'd7,
      AM_PCR  = 4'd8,
      AM_SPR  = 4'd9
   } amode_e;

   // How many reads an operation needs
   typedef enum logic [1:0] {
      RD_NONE = 2'd0,
      RD_ONE  = 2'd1,
      RD_TWO  = 2'd2
   } rdcnt_e;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_REQ1  = 3'd1,
      ST_RESP1 = 3'd2,
      ST_REQ2  = 3'd3,
      ST_RESP2 = 3'd4,
      ST_FIN   = 3'd5
   } seq_state_e;

endpackage

// File: rtl/opf_addr_calc.sv
module opf_addr_calc
   import opf_pkg::*;
#(
   parameter int AW           = 32,
   parameter int SEL_W        = 2,
   parameter bit SCALE_BY_MUL = 1'b0
) (
   input  logic [3:0]       mode_i,
   input  logic [AW-1:0]    r_i,
   input  logic [AW-1:0]    d_i,
   input  logic [AW-1:0]    pc_i,
   input  logic [AW-1:0]    sp_i,
   input  logic [SEL_W-1:0] scale_i,
   input  logic [SEL_W-1:0] step_i,
   output logic [AW-1:0]    addr_o,
   output logic [AW-1:0]    r_next_o,
   output rdcnt_e           reads_o,
   output logic             upd_o,
   output logic             illegal_o
);

   localparam int MAX_SHIFT = (1 << SEL_W) - 1;

   logic [AW-1:0] step_amt;
   logic [AW-1:0] scaled_r;

   assign step_amt = AW'(1) << step_i;

   generate
      if (SCALE_BY_MUL) begin : g_scale_mul
         logic [AW-1:0] factor;
         assign factor   = AW'(1) << scale_i;
         assign scaled_r = AW'(r_i * factor);
      end else begin : g_scale_shift
         assign scaled_r = r_i << scale_i;
      end
      if (MAX_SHIFT >= AW) begin : g_bad_shift
         $error("opf_addr_calc: scale/step range exceeds the data width");
      end
   endgenerate

   always_comb begin
      addr_o    = '0;
      r_next_o  = r_i;
      reads_o   = RD_ONE;
      upd_o     = 1'b0;
      illegal_o = 1'b0;
      case (mode_i)
         AM_IMM:  reads_o = RD_NONE;
         AM_DIR:  addr_o  = d_i;
         AM_RIND: addr_o  = r_i;
         AM_MIND: begin
            addr_o  = d_i;
            reads_o = RD_TWO;
         end
         AM_PINC: begin
            addr_o   = r_i;
            r_next_o = r_i + step_amt;
            upd_o    = 1'b1;
         end
         AM_PDEC: begin
            addr_o   = r_i - step_amt;
            r_next_o = r_i - step_amt;
            upd_o    = 1'b1;
         end
         AM_IDX:  addr_o = r_i + d_i;
         AM_SIB:  addr_o = scaled_r + d_i;
         AM_PCR:  addr_o = pc_i + d_i;
         AM_SPR:  addr_o = sp_i + d_i;
         default: begin
            reads_o   = RD_NONE;
            illegal_o = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/opf_seq.sv
module opf_seq
   import opf_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept_i,
   input  rdcnt_e        reads_i,
   input  logic          upd_i,
   input  logic          illegal_i,
   input  logic [AW-1:0] addr_i,
   input  logic [AW-1:0] imm_i,
   input  logic [AW-1:0] r_next_i,
   input  logic [AW-1:0] rdata_i,
   output logic          idle_o,
   output logic          mem_req_o,
   output logic [AW-1:0] mem_addr_o,
   output logic          done_o,
   output logic [AW-1:0] operand_o,
   output logic          err_o,
   output logic          reg_wr_en_o,
   output logic [AW-1:0] reg_wr_data_o
);

   seq_state_e    state_q;
   rdcnt_e        reads_q;
   logic          upd_q;
   logic          err_q;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] ptr_q;
   logic [AW-1:0] rnext_q;
   logic [AW-1:0] opnd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         reads_q <= RD_NONE;
         upd_q   <= 1'b0;
         err_q   <= 1'b0;
         addr_q  <= '0;
         ptr_q   <= '0;
         rnext_q <= '0;
         opnd_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (accept_i) begin
               reads_q <= reads_i;
               upd_q   <= upd_i;
               err_q   <= illegal_i;
               addr_q  <= addr_i;
               rnext_q <= r_next_i;
               if (reads_i == RD_NONE) begin
                  opnd_q  <= illegal_i ? '0 : imm_i;
                  state_q <= ST_FIN;
               end else begin
                  state_q <= ST_REQ1;
               end
            end
            ST_REQ1:  state_q <= ST_RESP1;
            ST_RESP1: begin
               if (reads_q == RD_TWO) begin
                  ptr_q   <= rdata_i;
                  state_q <= ST_REQ2;
               end else begin
                  opnd_q  <= rdata_i;
                  state_q <= ST_FIN;
               end
            end
            ST_REQ2:  state_q <= ST_RESP2;
            ST_RESP2: begin
               opnd_q  <= rdata_i;
               state_q <= ST_FIN;
            end
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   assign idle_o        = (state_q == ST_IDLE);
   assign mem_req_o     = (state_q == ST_REQ1) || (state_q == ST_REQ2);
   assign mem_addr_o    = (state_q == ST_REQ2) ? ptr_q : addr_q;
   assign done_o        = (state_q == ST_FIN);
   assign operand_o     = opnd_q;
   assign err_o         = done_o && err_q;
   assign reg_wr_en_o   = done_o && upd_q;
   assign reg_wr_data_o = rnext_q;

   // R13: a completion lasts one cycle
   a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R10: register update strobe only in a completion cycle
   a_r10_wr_only_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en_o |-> done_o);

   // R9: error flag only in a completion cycle, never alongside an update
   a_r9_err_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (done_o && !reg_wr_en_o));

   // R3: a request is followed by a response cycle, not by another request or done
   a_r3_req_then_resp: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> (!mem_req_o && !done_o));

   // R12: while busy the sequencer never reports idle before finishing
   a_r12_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_o && !done_o) |=> !idle_o);

endmodule

// File: rtl/opf_unit.sv
module opf_unit
   import opf_pkg::*;
#(
   parameter int AW           = 32,
   parameter bit SCALE_BY_MUL = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [3:0]    mode,
   input  logic [AW-1:0] reg_val,
   input  logic [AW-1:0] disp,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] sp,
   input  logic [1:0]    scale_sel,
   input  logic [1:0]    step_sel,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic [AW-1:0] mem_rdata,
   output logic          done,
   output logic [AW-1:0] operand,
   output logic          err,
   output logic          reg_wr_en,
   output logic [AW-1:0] reg_wr_data
);

   localparam int SEL_W = 2;

   generate
      if (AW < 8 || AW > 64) begin : g_bad_width
         $error("opf_unit: AW must lie between 8 and 64");
      end
   endgenerate

   logic          idle;
   logic          accept;
   logic [AW-1:0] ea;
   logic [AW-1:0] r_next;
   rdcnt_e        reads;
   logic          upd;
   logic          illegal;

   assign accept = start && idle;

   opf_addr_calc #(
      .AW           (AW),
      .SEL_W        (SEL_W),
      .SCALE_BY_MUL (SCALE_BY_MUL)
   ) i_calc (
      .mode_i    (mode),
      .r_i       (reg_val),
      .d_i       (disp),
      .pc_i      (pc),
      .sp_i      (sp),
      .scale_i   (scale_sel),
      .step_i    (step_sel),
      .addr_o    (ea),
      .r_next_o  (r_next),
      .reads_o   (reads),
      .upd_o     (upd),
      .illegal_o (illegal)
   );

   opf_seq #(
      .AW (AW)
   ) i_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .accept_i      (accept),
      .reads_i       (reads),
      .upd_i         (upd),
      .illegal_i     (illegal),
      .addr_i        (ea),
      .imm_i         (disp),
      .r_next_i      (r_next),
      .rdata_i       (mem_rdata),
      .idle_o        (idle),
      .mem_req_o     (mem_req),
      .mem_addr_o    (mem_addr),
      .done_o        (done),
      .operand_o     (operand),
      .err_o         (err),
      .reg_wr_en_o   (reg_wr_en),
      .reg_wr_data_o (reg_wr_data)
   );

   // R2/R9: an accepted immediate or illegal code completes on the next cycle with no request
   a_r2_fast_path: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (mode == 4'd0 || mode > 4'd9)) |=> (done && !mem_req));

   // R10: modes without register update never strobe the write
   a_r10_no_upd_other_modes: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && mode != 4'd4 && mode != 4'd5) |=> !reg_wr_en);

endmodule

// File: tb/test_opf_unit.sv
module test_opf_unit;

   localparam int AW = 32;

   typedef struct {
      logic [AW-1:0] opnd;
      logic          err;
      logic          wr;
      logic [AW-1:0] wdata;
      int            nreads;
      logic [AW-1:0] addr1;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [3:0]    mode = '0;
   logic [AW-1:0] reg_val = '0, disp = '0, pc = '0, sp = '0;
   logic [1:0]    scale_sel = '0, step_sel = '0;
   logic          mem_req, done, err, reg_wr_en;
   logic [AW-1:0] mem_addr, operand, reg_wr_data;
   logic [AW-1:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   exp_t sb[$];
   int req_cnt = 0;
   logic [AW-1:0] first_addr = '0;

   always #5 clk = ~clk;

   opf_unit #(.AW(AW)) i_opf_unit (
      .clk (clk), .rst_n (rst_n), .start (start), .mode (mode),
      .reg_val (reg_val), .disp (disp), .pc (pc), .sp (sp),
      .scale_sel (scale_sel), .step_sel (step_sel),
      .mem_req (mem_req), .mem_addr (mem_addr), .mem_rdata (mem_rdata),
      .done (done), .operand (operand), .err (err),
      .reg_wr_en (reg_wr_en), .reg_wr_data (reg_wr_data)
   );

   function automatic logic [AW-1:0] mem_f(input logic [AW-1:0] a);
      return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1;
   endfunction

   // Memory model: one-cycle read latency
   always @(posedge clk) if (mem_req) mem_rdata <= mem_f(mem_addr);

   task automatic chk(input bit ok, input string tag, input logic [AW-1:0] act,
                      input logic [AW-1:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, expv);
      end
   endtask

   // Monitor: counts requests and compares each completion with the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req) begin
            if (req_cnt == 0) first_addr = mem_addr;
            req_cnt++;
         end
         if (done) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R12 unexpected done", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(operand == e.opnd, {e.tag, " operand"}, operand, e.opnd);
               chk(err == e.err, {e.tag, " err"}, 32'(err), 32'(e.err));
               chk(reg_wr_en == e.wr, {e.tag, " R10 wr_en"}, 32'(reg_wr_en), 32'(e.wr));
               if (e.wr) chk(reg_wr_data == e.wdata, {e.tag, " wr_data"}, reg_wr_data, e.wdata);
               chk(req_cnt == e.nreads, {e.tag, " read count"}, 32'(req_cnt), 32'(e.nreads));
               if (e.nreads > 0) chk(first_addr == e.addr1, {e.tag, " address"}, first_addr, e.addr1);
            end
            req_cnt = 0;
         end
         if (reg_wr_en && !done) chk(1'b0, "R10 strobe outside done", 32'd1, 32'd0);
      end
   end

   task automatic run(input logic [3:0] m, input logic [AW-1:0] r, input logic [AW-1:0] d,
                      input logic [AW-1:0] p, input logic [AW-1:0] s,
                      input logic [1:0] sc, input logic [1:0] st,
                      input bit poke, input string tag);
      exp_t e;
      int lat_exp;
      int lat;
      logic [AW-1:0] n;
      n = AW'(1) << st;                        // R8
      e.opnd = '0; e.err = 1'b0; e.wr = 1'b0; e.wdata = '0;
      e.nreads = 1; e.addr1 = '0; e.tag = tag;
      case (m)
         4'd0: begin e.opnd = d; e.nreads = 0; end
         4'd1: e.addr1 = d;
         4'd2: e.addr1 = r;
         4'd3: begin e.addr1 = d; e.nreads = 2; end
         4'd4: begin e.addr1 = r; e.wr = 1'b1; e.wdata = r + n; end
         4'd5: begin e.addr1 = r - n; e.wr = 1'b1; e.wdata = r - n; end
         4'd6: e.addr1 = r + d;
         4'd7: e.addr1 = (r << sc) + d;
         4'd8: e.addr1 = p + d;
         4'd9: e.addr1 = s + d;
         default: begin e.err = 1'b1; e.nreads = 0; end
      endcase
      if (e.nreads == 1) e.opnd = mem_f(e.addr1);
      if (e.nreads == 2) e.opnd = mem_f(mem_f(e.addr1));
      lat_exp = (e.nreads == 0) ? 1 : (e.nreads == 1 ? 3 : 5);
      sb.push_back(e);
      @(negedge clk);
      mode = m; reg_val = r; disp = d; pc = p; sp = s;
      scale_sel = sc; step_sel = st; start = 1'b1;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
         start = 1'b0;
         if (poke && lat == 1) begin
            // R12: a start with different inputs while busy
            start = 1'b1; mode = 4'd0; disp = 32'hDEAD_0000; reg_val = 32'h0;
         end
      end while (!done && lat < 20);
      start = 1'b0;
      chk(lat == lat_exp, {tag, " latency"}, 32'(lat), 32'(lat_exp));
      @(negedge clk);
      chk(!done, {tag, " R13 done single cycle"}, 32'(done), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!done && !mem_req && !reg_wr_en && !err, "R1 reset outputs",
          {28'd0, done, mem_req, reg_wr_en, err}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!done && !mem_req && !reg_wr_en && !err, "R1 after release",
          {28'd0, done, mem_req, reg_wr_en, err}, 32'd0);

      run(4'd0, 32'h0, 32'h1234_5678, 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, "R2 immediate");
      run(4'd1, 32'h0, 32'h0000_0100, 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, "R3 direct");
      run(4'd2, 32'h0000_2000, 32'h0, 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, "R3 reg indirect");
      run(4'd6, 32'h0000_3000, 32'h44, 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, "R3 indexed");
      run(4'd8, 32'h0, 32'h10, 32'h0000_8000, 32'h0, 2'd0, 2'd0, 1'b0, "R3 pc relative");
      run(4'd9, 32'h0, 32'hFFFF_FFFC, 32'h0, 32'h0000_7000, 2'd0, 2'd0, 1'b0, "R3 sp relative");
      run(4'd3, 32'h0, 32'h0000_0040, 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, "R4 memory indirect");
      for (int k = 0; k < 4; k++)
         run(4'd7, 32'h0000_0123, 32'h0000_1000, 32'h0, 32'h0, 2'(k), 2'd0, 1'b0, "R5 scaled index");
      for (int k = 0; k < 4; k++)
         run(4'd4, 32'h0000_1000, 32'h0, 32'h0, 32'h0, 2'd0, 2'(k), 1'b0, "R6 R8 post increment");
      for (int k = 0; k < 4; k++)
         run(4'd5, 32'h0000_1000, 32'h0, 32'h0, 32'h0, 2'd0, 2'(k), 1'b0, "R7 R8 pre decrement");
      run(4'd5, 32'h0000_0004, 32'h0, 32'h0, 32'h0, 2'd0, 2'd3, 1'b0, "R11 decrement wrap");
      run(4'd4, 32'hFFFF_FFFE, 32'h0, 32'h0, 32'h0, 2'd0, 2'd2, 1'b0, "R11 increment wrap");
      run(4'd6, 32'hFFFF_FFF0, 32'h20, 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, "R11 indexed wrap");
      run(4'd7, 32'h8000_0001, 32'h4, 32'h0, 32'h0, 2'd3, 2'd0, 1'b0, "R11 scaled wrap");
      run(4'd10, 32'h0, 32'h5555_5555, 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, "R9 illegal 10");
      run(4'd15, 32'h0, 32'h5555_5555, 32'h0, 32'h0, 2'd0, 2'd0, 1'b0, "R9 illegal 15");
      run(4'd1, 32'h0, 32'h0000_0abc, 32'h0, 32'h0, 2'd0, 2'd0, 1'b1, "R12 start while busy");
      run(4'd3, 32'h0, 32'h0000_0777, 32'h0, 32'h0, 2'd0, 2'd0, 1'b1, "R12 busy indirect");

      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R12 scoreboard drained", 32'(sb.size()), 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule